// File: doc/BRIEF.md
# Lamp Inverter Protection Sequencer

This block is the mode and fault controller of a half-bridge lamp inverter. Its inputs are comparator flags that have already been digitised: lamp feedback low, regulation warning, regulation limit, arc, short circuit, compensation high, over-temperature, supply good and enable. It also receives single-cycle ticks from the burst-dimming oscillator and from the main switching oscillator. When the supply is good and the block is enabled, it moves from off into striking mode. It moves from striking into normal running once the lamp has lit. Otherwise it shuts down when the striking window runs out.

While striking or running, each fault has its own delay counter, counted in burst periods. The limit depends on the mode: long while striking and short while running. Arc faults are counted on the main oscillator instead, and over-temperature trips at once. Only an unbroken fault trips. Any trip latches shutdown, raises a one-cycle pulse and records a cause code. The latch clears only when the supply-good flag or enable goes low. Burst dimming is permitted only in normal running, so striking is never interrupted.

Top module: `lamp_prot_seq`

## Requirements
- R1: After reset, and whenever `supply_ok` or `enable` is low (taking effect one clock later), `mode` is OFF (0), `cause` is 0, and `shutdown` and `burst_allow` are 0. From OFF with both high, `mode` becomes STRIKE (1) one clock later.
- R2: In STRIKE, a `burst_tick` with `fb_low` low moves `mode` to RUN (2) on the next clock. `burst_allow` is 1 exactly while `mode` is RUN.
- R3: If the 450th `burst_tick` since entering STRIKE arrives with `fb_low` high, the block enters HALT (3) with `cause` 8.
- R4: `burst_allow` stays 0 for every cycle spent in STRIKE.
- R5: In RUN, `fb_low` held high across 3 burst ticks trips with `cause` 7.
- R6: `short_flt` held high trips on its 450th burst tick in STRIKE, or on its 32nd in RUN, with `cause` 3.
- R7: `comp_high` uses the same 450/32 burst-tick delays and trips with `cause` 4.
- R8: `reg_limit` uses the 450/32 delays and trips with `cause` 5. `reg_warn` uses 451/3 and trips with `cause` 6.
- R9: `arc` held high across 2 `main_tick` pulses trips with `cause` 2. Burst ticks do not advance this count.
- R10: `over_temp` in STRIKE or RUN trips on the next clock with `cause` 1.
- R11: A fault flag that drops before its count completes restarts that count from zero.
- R12: In HALT, `shutdown` is 1 and HALT holds, whatever the fault flags do, until `supply_ok` or `enable` goes low.
- R13: `trip_pulse` is high only in the first HALT cycle, and `cause` holds its value for the whole of HALT.
- R14: When several trips occur in the same cycle, the lowest nonzero cause code is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply above undervoltage threshold |
| enable | input | 1 | Block enable |
| fb_low | input | 1 | Lamp feedback below threshold |
| reg_warn | input | 1 | Open-lamp regulation warning level |
| reg_limit | input | 1 | Open-lamp regulation limit level |
| arc | input | 1 | Arc comparator flag |
| short_flt | input | 1 | Short-circuit comparator flag |
| comp_high | input | 1 | Compensation node too high |
| over_temp | input | 1 | Over-temperature flag |
| burst_tick | input | 1 | One pulse per burst oscillator period |
| main_tick | input | 1 | One pulse per main oscillator period |
| mode | output | 2 | 0 OFF, 1 STRIKE, 2 RUN, 3 HALT |
| shutdown | output | 1 | Shutdown latched |
| burst_allow | output | 1 | Burst dimming permitted |
| trip_pulse | output | 1 | One-cycle pulse on entering HALT |
| cause | output | 4 | Fault cause code, held in HALT |

## Verification
A delay counter in a wrong state shows up on `mode` as a trip one burst tick early or late. A counter that keeps stale counts after its flag drops trips on a fault pulse train that should pass. A latch or cause register fault shows on `shutdown`, `cause` and `trip_pulse` in the first HALT cycle, or in the clock after a flag toggles while halted. Every scenario samples the outputs in the cycle right after the deciding tick, so an off-by-one error appears at once and not after many cycles.

// File: rtl/lamp_prot_pkg.sv
package lamp_prot_pkg;

    typedef enum logic [1:0] {
        M_OFF    = 2'd0,
        M_STRIKE = 2'd1,
        M_RUN    = 2'd2,
        M_HALT   = 2'd3
    } mode_e;

    typedef enum logic [3:0] {
        C_NONE   = 4'd0,
        C_OTEMP  = 4'd1,
        C_ARC    = 4'd2,
        C_SHORT  = 4'd3,
        C_COMP   = 4'd4,
        C_LIMIT  = 4'd5,
        C_WARN   = 4'd6,
        C_OPEN   = 4'd7,
        C_STRIKE = 4'd8
    } cause_e;

    // timed fault slots; slot i reports cause code i + 2
    localparam int NUM_TIMED = 6;
    localparam int SLOT_ARC   = 0;
    localparam int SLOT_SHORT = 1;
    localparam int SLOT_COMP  = 2;
    localparam int SLOT_LIMIT = 3;
    localparam int SLOT_WARN  = 4;
    localparam int SLOT_OPEN  = 5;

    localparam int DEF_STRIKE_CYC = 450;
    localparam int DEF_FLT_STRIKE = 450;
    localparam int DEF_FLT_RUN    = 32;
    localparam int DEF_WARN_STR   = 451;
    localparam int DEF_WARN_RUN   = 3;
    localparam int DEF_OPEN_RUN   = 3;
    localparam int DEF_ARC_MAIN   = 2;

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic cause_e slot_cause(int slot);
        return cause_e'(4'(slot + 2));
    endfunction

endpackage

// File: rtl/fault_timer.sv
module fault_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             flag,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    logic [CNT_W-1:0] count_q;
    logic [CNT_W:0]   count_nx;

    assign count_nx = {1'b0, count_q} + {{CNT_W{1'b0}}, 1'b1};
    assign expire   = !clr && flag && tick && (count_nx >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst || clr || !flag) begin
            count_q <= '0;
        end else if (tick && !expire) begin
            count_q <= count_nx[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/fault_bank.sv
module fault_bank
    import lamp_prot_pkg::*;
#(
    parameter int CNT_W      = 9,
    parameter int FLT_STRIKE = DEF_FLT_STRIKE,
    parameter int FLT_RUN    = DEF_FLT_RUN,
    parameter int WARN_STR   = DEF_WARN_STR,
    parameter int WARN_RUN   = DEF_WARN_RUN,
    parameter int OPEN_RUN   = DEF_OPEN_RUN,
    parameter int ARC_MAIN   = DEF_ARC_MAIN
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 in_run,
    input  logic [NUM_TIMED-1:0] flags,
    input  logic                 burst_tick,
    input  logic                 main_tick,
    output logic [NUM_TIMED-1:0] expire
);
    localparam int LIM_STRIKE [NUM_TIMED] =
        '{ARC_MAIN, FLT_STRIKE, FLT_STRIKE, FLT_STRIKE, WARN_STR, OPEN_RUN};
    localparam int LIM_RUN [NUM_TIMED] =
        '{ARC_MAIN, FLT_RUN, FLT_RUN, FLT_RUN, WARN_RUN, OPEN_RUN};

    for (genvar i = 0; i < NUM_TIMED; i++) begin : g_slot
        logic [CNT_W-1:0] lim;
        logic             tk;
        assign lim = in_run ? CNT_W'(LIM_RUN[i]) : CNT_W'(LIM_STRIKE[i]);
        if (i == SLOT_ARC) begin : g_main
            assign tk = main_tick;
        end else begin : g_burst
            assign tk = burst_tick;
        end
        fault_timer #(.CNT_W(CNT_W)) u_tmr (
            .clk    (clk),
            .rst    (rst),
            .clr    (clr),
            .flag   (flags[i]),
            .tick   (tk),
            .limit  (lim),
            .expire (expire[i])
        );
    end
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
    import lamp_prot_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 active,
    input  logic                 fb_low,
    input  logic                 burst_tick,
    input  logic                 over_temp,
    input  logic                 strike_exp,
    input  logic [NUM_TIMED-1:0] expire,
    output mode_e                mode_q,
    output cause_e               cause_q,
    output logic                 pulse_q
);
    mode_e  mode_d;
    cause_e cause_d;
    cause_e first_cause;
    logic   any_exp;

    // lowest slot wins
    always_comb begin
        first_cause = C_NONE;
        any_exp     = 1'b0;
        for (int i = NUM_TIMED - 1; i >= 0; i--) begin
            if (expire[i]) begin
                first_cause = slot_cause(i);
                any_exp     = 1'b1;
            end
        end
    end

    always_comb begin
        mode_d  = mode_q;
        cause_d = cause_q;
        if (!active) begin
            mode_d  = M_OFF;
            cause_d = C_NONE;
        end else begin
            unique case (mode_q)
                M_OFF: mode_d = M_STRIKE;
                M_STRIKE, M_RUN: begin
                    if (over_temp) begin
                        mode_d  = M_HALT;
                        cause_d = C_OTEMP;
                    end else if (any_exp) begin
                        mode_d  = M_HALT;
                        cause_d = first_cause;
                    end else if (mode_q == M_STRIKE && burst_tick) begin
                        if (!fb_low) begin
                            mode_d = M_RUN;
                        end else if (strike_exp) begin
                            mode_d  = M_HALT;
                            cause_d = C_STRIKE;
                        end
                    end
                end
                default: mode_d = M_HALT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= M_OFF;
            cause_q <= C_NONE;
            pulse_q <= 1'b0;
        end else begin
            mode_q  <= mode_d;
            cause_q <= cause_d;
            pulse_q <= (mode_d == M_HALT) && (mode_q != M_HALT);
        end
    end
endmodule

// File: rtl/lamp_prot_seq.sv
module lamp_prot_seq
    import lamp_prot_pkg::*;
#(
    parameter int STRIKE_CYC = DEF_STRIKE_CYC,
    parameter int FLT_STRIKE = DEF_FLT_STRIKE,
    parameter int FLT_RUN    = DEF_FLT_RUN,
    parameter int WARN_STR   = DEF_WARN_STR,
    parameter int WARN_RUN   = DEF_WARN_RUN,
    parameter int OPEN_RUN   = DEF_OPEN_RUN,
    parameter int ARC_MAIN   = DEF_ARC_MAIN
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_ok,
    input  logic       enable,
    input  logic       fb_low,
    input  logic       reg_warn,
    input  logic       reg_limit,
    input  logic       arc,
    input  logic       short_flt,
    input  logic       comp_high,
    input  logic       over_temp,
    input  logic       burst_tick,
    input  logic       main_tick,
    output logic [1:0] mode,
    output logic       shutdown,
    output logic       burst_allow,
    output logic       trip_pulse,
    output logic [3:0] cause
);
    localparam int MAX_LIM = max2(max2(max2(STRIKE_CYC, FLT_STRIKE), max2(FLT_RUN, WARN_STR)),
                                  max2(max2(WARN_RUN, OPEN_RUN), ARC_MAIN));
    localparam int CNT_W   = $clog2(MAX_LIM + 1);

    mode_e                mode_q;
    cause_e               cause_q;
    logic                 pulse_q;
    logic                 active, in_strike, in_run, tmr_clr, strike_exp;
    logic [NUM_TIMED-1:0] flags, expire;

    assign active    = supply_ok && enable;
    assign in_strike = (mode_q == M_STRIKE);
    assign in_run    = (mode_q == M_RUN);
    assign tmr_clr   = !active || !(in_strike || in_run);

    always_comb begin
        flags             = '0;
        flags[SLOT_ARC]   = arc;
        flags[SLOT_SHORT] = short_flt;
        flags[SLOT_COMP]  = comp_high;
        flags[SLOT_LIMIT] = reg_limit;
        flags[SLOT_WARN]  = reg_warn;
        flags[SLOT_OPEN]  = fb_low && in_run;
    end

    fault_bank #(
        .CNT_W      (CNT_W),
        .FLT_STRIKE (FLT_STRIKE),
        .FLT_RUN    (FLT_RUN),
        .WARN_STR   (WARN_STR),
        .WARN_RUN   (WARN_RUN),
        .OPEN_RUN   (OPEN_RUN),
        .ARC_MAIN   (ARC_MAIN)
    ) u_bank (
        .clk        (clk),
        .rst        (rst),
        .clr        (tmr_clr),
        .in_run     (in_run),
        .flags      (flags),
        .burst_tick (burst_tick),
        .main_tick  (main_tick),
        .expire     (expire)
    );

    // striking window: counts every burst tick spent in STRIKE
    fault_timer #(.CNT_W(CNT_W)) u_strike (
        .clk    (clk),
        .rst    (rst),
        .clr    (!active || !in_strike),
        .flag   (in_strike),
        .tick   (burst_tick),
        .limit  (CNT_W'(STRIKE_CYC)),
        .expire (strike_exp)
    );

    mode_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .active     (active),
        .fb_low     (fb_low),
        .burst_tick (burst_tick),
        .over_temp  (over_temp),
        .strike_exp (strike_exp),
        .expire     (expire),
        .mode_q     (mode_q),
        .cause_q    (cause_q),
        .pulse_q    (pulse_q)
    );

    assign mode        = mode_q;
    assign cause       = cause_q;
    assign trip_pulse  = pulse_q;
    assign shutdown    = (mode_q == M_HALT);
    assign burst_allow = in_run;
endmodule

// File: rtl/lamp_prot_chk.sv
module lamp_prot_chk (
    input logic       clk,
    input logic       rst,
    input logic       supply_ok,
    input logic       enable,
    input logic       fb_low,
    input logic       reg_warn,
    input logic       reg_limit,
    input logic       arc,
    input logic       short_flt,
    input logic       comp_high,
    input logic       over_temp,
    input logic       burst_tick,
    input logic       main_tick,
    input logic [1:0] mode,
    input logic       shutdown,
    input logic       burst_allow,
    input logic       trip_pulse,
    input logic [3:0] cause
);
    // R1
    off_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !(supply_ok && enable) |=> (mode == 2'd0) && (cause == 4'd0));

    // R4
    strike_noburst_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1) |-> !burst_allow);

    // R10
    otemp_trip_chk: assert property (@(posedge clk) disable iff (rst)
        (supply_ok && enable && over_temp && (mode == 2'd1 || mode == 2'd2))
        |=> shutdown && (cause == 4'd1));

    // R12
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (shutdown && supply_ok && enable) |=> shutdown);

    // R13
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        trip_pulse |=> !trip_pulse);

    // R13
    pulse_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(shutdown) |-> trip_pulse);

    // R13
    cause_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (shutdown && $past(shutdown)) |-> $stable(cause));

    // R12
    halt_cause_chk: assert property (@(posedge clk) disable iff (rst)
        shutdown |-> (cause != 4'd0));
endmodule

bind lamp_prot_seq lamp_prot_chk u_chk (.*);

// File: tb/sim_lamp_prot_seq.sv
module sim_lamp_prot_seq;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_ok = 1'b0, enable = 1'b0, fb_low = 1'b0, reg_warn = 1'b0;
    logic reg_limit = 1'b0, arc = 1'b0, short_flt = 1'b0, comp_high = 1'b0;
    logic over_temp = 1'b0, burst_tick = 1'b0, main_tick = 1'b0;
    logic [1:0] mode;
    logic       shutdown, burst_allow, trip_pulse;
    logic [3:0] cause;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    lamp_prot_seq u0 (.*);

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive at negedge, sample after the following posedge
    task automatic step(input logic bt, input logic mt);
        @(negedge clk);
        burst_tick = bt;
        main_tick  = mt;
        @(posedge clk);
        #1;
        burst_tick = 1'b0;
        main_tick  = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0);
    endtask

    task automatic quiet();
        fb_low = 0; reg_warn = 0; reg_limit = 0; arc = 0;
        short_flt = 0; comp_high = 0; over_temp = 0;
    endtask

    // off, then STRIKE with lamp unlit
    task automatic to_strike();
        quiet();
        enable = 0; step(0, 0);
        enable = 1; supply_ok = 1; fb_low = 1; step(0, 0);
    endtask

    task automatic to_run();
        to_strike();
        fb_low = 0; step(1, 0);
    endtask

    task automatic t_reset();
        chk("R1 mode", mode, 0);
        chk("R1 shutdown", shutdown, 0);
        chk("R1 cause", cause, 0);
        chk("R1 burst_allow", burst_allow, 0);
    endtask

    task automatic t_start();
        to_strike();
        chk("R1 strike entry", mode, 1);
        chk("R4 burst off", burst_allow, 0);
        ticks(5);
        chk("R4 strike unlit", mode, 1);
        fb_low = 0; step(0, 0);
        chk("R2 waits tick", mode, 1);
        step(1, 0);
        chk("R2 run", mode, 2);
        chk("R2 burst on", burst_allow, 1);
    endtask

    task automatic t_open_and_clear();
        to_run();
        fb_low = 1; ticks(2);
        chk("R5 before", mode, 2);
        ticks(1);
        chk("R5 halt", mode, 3);
        chk("R5 cause", cause, 7);
        chk("R13 pulse", trip_pulse, 1);
        step(0, 0);
        chk("R13 pulse gone", trip_pulse, 0);
        fb_low = 0; over_temp = 1; arc = 1; ticks(3);
        chk("R12 hold", shutdown, 1);
        chk("R13 cause hold", cause, 7);
        over_temp = 0; arc = 0;
        enable = 0; step(0, 0);
        chk("R12 enable clear", mode, 0);
        chk("R1 cause clear", cause, 0);
        to_run(); fb_low = 1; ticks(3);
        supply_ok = 0; step(0, 0);
        chk("R12 supply clear", shutdown, 0);
    endtask

    task automatic t_strike_timeout();
        to_strike();
        ticks(449);
        chk("R3 before", mode, 1);
        ticks(1);
        chk("R3 halt", mode, 3);
        chk("R3 cause", cause, 8);
    endtask

    task automatic t_short();
        to_run();
        short_flt = 1; ticks(20);
        short_flt = 0; step(0, 0);
        short_flt = 1; ticks(31);
        chk("R11 restart", mode, 2);
        ticks(1);
        chk("R6 run trip", cause, 3);
        to_strike();
        short_flt = 1; ticks(449);
        chk("R6 strike before", mode, 1);
        ticks(1);
        chk("R14 short over timeout", cause, 3);
    endtask

    task automatic t_others();
        to_run(); comp_high = 1; ticks(31);
        chk("R7 before", mode, 2);
        ticks(1);
        chk("R7 cause", cause, 4);
        to_run(); reg_limit = 1; ticks(32);
        chk("R8 limit cause", cause, 5);
        to_run(); reg_warn = 1; ticks(2);
        chk("R8 warn before", mode, 2);
        ticks(1);
        chk("R8 warn cause", cause, 6);
        to_run(); arc = 1; ticks(4); step(0, 1);
        chk("R9 burst ignored", mode, 2);
        step(0, 1);
        chk("R9 cause", cause, 2);
        to_run(); over_temp = 1; step(0, 0);
        chk("R10 cause", cause, 1);
        to_run(); comp_high = 1; reg_limit = 1; ticks(32);
        chk("R14 priority", cause, 4);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        t_reset();
        t_start();
        t_open_and_clear();
        t_strike_timeout();
        t_short();
        t_others();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule